// File: doc/BRIEF.md
# GPIO Input Sample Qualifier

This block filters a 32-pin input port before the values reach the GPIO data register and the peripheral inputs. Every pin first passes a two-flop synchroniser. A 2-bit mode per pin then selects one of four behaviours:

- synchronise only;
- accept a new level only after 3 matching samples;
- accept a new level only after 6 matching samples;
- pass the raw pin straight to the peripheral side.

Samples are taken on a strobe that comes from a per-group divider. Each group of eight consecutive pins shares one 8-bit period field. A value of zero samples on every clock. A value n samples once every 2n clocks.

Software programs the modes and periods through a small word-wide write/read port. The filtered levels leave on two 32-bit buses. One feeds the GPIO data register. The other feeds peripheral inputs, and only this one honours the raw bypass mode.

Top module: `gpio_in_qual`

## Requirements
- R1: After reset, both output buses are all zero, and every register reads zero. A zero mode register means sync-only mode for every pin. A zero period register means sampling on every clock.
- R2: Mode registers and the period register are laid out as follows:
  - Address 0 holds the modes of pins 15..0, with pin k at bits 2k+1:2k.
  - Address 1 holds the modes of pins 31..16, with pin k at bits 2(k-16)+1:2(k-16).
  - Address 2 holds the periods, with group g (pins 8g..8g+7) at bits 8g+7:8g.
  - Written values read back unchanged, and address 3 reads zero.
- R3: In mode 00 (sync only), a level applied before rising edge 1 appears on both outputs after rising edge 3 and not earlier.
- R4: In mode 01, the output takes a new level only when three consecutive samples agree, and otherwise holds. With period 0, a pulse lasting 2 clocks is rejected. A pulse lasting 3 clocks is accepted after rising edge 5, counted from a change before edge 1.
- R5: In mode 10, six consecutive agreeing samples are required. With period 0, a 5-clock pulse is rejected, and a steady level appears after rising edge 8 and not after edge 7.
- R6: In mode 11, the peripheral output equals the raw pin with no clock delay. The GPIO output behaves exactly as in mode 00.
- R7: A period field n from 1 to 255 samples once every 2n clocks. Writing address 2 restarts every group's divider, so the first sample falls on edge 2n after the write edge.
- R8: A period field affects only its own eight pins. Pins in other groups keep their own sampling rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| pin_i | input | 32 | Raw pin levels |
| gpio_dat_o | output | 32 | Qualified levels toward the GPIO data register |
| periph_o | output | 32 | Qualified or bypassed levels toward peripherals |

## Verification
Each mode is driven with a steady level change and with pulses just shorter and just longer than its sample window. A 2-clock and a 3-clock pulse in 3-sample mode, and a 5-clock pulse in 6-sample mode, separate a correct agreement count from one that is off by one. The exact latency checks, made one cycle before and at the expected edge, separate sync-only, 3-sample and 6-sample paths and the raw bypass. A step applied right after a period write, with two groups at different periods and a third at zero, exposes a wrong divide ratio, a missing divider restart, or one group's field leaking into another.

// File: rtl/gpq_pkg.sv
package gpq_pkg;
  typedef enum logic [1:0] {
    QM_SYNC  = 2'b00,
    QM_Q3    = 2'b01,
    QM_Q6    = 2'b10,
    QM_ASYNC = 2'b11
  } qmode_e;
endpackage

// File: rtl/gpq_regs.sv
module gpq_regs #(
  parameter int NPINS   = 32,
  parameter int NGROUPS = 4,
  parameter int PERW    = 8,
  parameter int DW      = 32,
  parameter int AW      = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DW-1:0]           wdata_i,
  output logic [DW-1:0]           rdata_o,
  output logic [2*NPINS-1:0]      mode_o,
  output logic [NGROUPS*PERW-1:0] period_o,
  output logic                    per_wr_o
);
  localparam int NMREG = (2 * NPINS) / DW;
  localparam int PBITS = NGROUPS * PERW;

  logic [NMREG-1:0][DW-1:0] mode_q;
  logic [PBITS-1:0]         period_q;

  assign per_wr_o = we_i && (addr_i == AW'(NMREG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      period_q <= '0;
    end else if (we_i) begin
      for (int m = 0; m < NMREG; m++)
        if (addr_i == AW'(m)) mode_q[m] <= wdata_i;
      if (per_wr_o) period_q <= wdata_i[PBITS-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int m = 0; m < NMREG; m++)
      if (addr_i == AW'(m)) rdata_o = mode_q[m];
    if (addr_i == AW'(NMREG)) rdata_o = DW'(period_q);
  end

  assign mode_o   = mode_q;
  assign period_o = period_q;
endmodule

// File: rtl/gpq_strobe.sv
module gpq_strobe #(
  parameter int PERW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PERW-1:0] period_i,
  input  logic            reload_i,
  output logic            strobe_o
);
  localparam int CW = PERW + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  // sample every 2n clocks; count 0 .. 2n-1
  assign limit    = {period_i, 1'b0} - CW'(1);
  assign strobe_o = (period_i == '0) || (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (reload_i || strobe_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + CW'(1);
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_i != '0) |-> (cnt_q <= limit));
endmodule

// File: rtl/gpq_pin.sv
module gpq_pin
  import gpq_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  qmode_e mode_i,
  input  logic   strobe_i,
  output logic   gpio_o,
  output logic   periph_o
);
  logic             s1_q, s2_q, q_q;
  logic [DEPTH-2:0] sh_q;
  logic             agree3, agree6;

  assign agree3 = (sh_q[1:0] == {2{s2_q}});
  assign agree6 = (sh_q == {(DEPTH-1){s2_q}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      sh_q <= '0;
      q_q  <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      if (strobe_i) sh_q <= {sh_q[DEPTH-3:0], s2_q};
      unique case (mode_i)
        QM_Q3:   if (strobe_i && agree3) q_q <= s2_q;
        QM_Q6:   if (strobe_i && agree6) q_q <= s2_q;
        default: q_q <= s2_q;
      endcase
    end
  end

  assign gpio_o   = q_q;
  assign periph_o = (mode_i == QM_ASYNC) ? pin_i : q_q;

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R3
  sync_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && ($past(mode_i) == QM_SYNC || $past(mode_i) == QM_ASYNC))
      |-> (gpio_o == $past(pin_i, 3)));
  // R4
  q_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && (mode_i == QM_Q3 || mode_i == QM_Q6)) |=> $stable(gpio_o));
  // R4
  q3_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == QM_Q3 && !(sh_q[1] == s2_q && sh_q[0] == s2_q))
      |=> $stable(gpio_o));
  // R5
  q6_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && mode_i == QM_Q6 && ($countones({sh_q, s2_q}) != 0)
      && ($countones({sh_q, s2_q}) != DEPTH)) |=> $stable(gpio_o));
endmodule

// File: rtl/gpio_in_qual.sv
module gpio_in_qual
  import gpq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int GROUP = 8,
  parameter int PERW  = 8,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] gpio_dat_o,
  output logic [NPINS-1:0] periph_o
);
  localparam int NGROUPS = NPINS / GROUP;

  logic [2*NPINS-1:0]      mode_w;
  logic [NGROUPS*PERW-1:0] period_w;
  logic                    per_wr;
  logic [NGROUPS-1:0]      strobe_w;

  gpq_regs #(
    .NPINS(NPINS), .NGROUPS(NGROUPS), .PERW(PERW), .DW(DW), .AW(AW)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .mode_o   (mode_w),
    .period_o (period_w),
    .per_wr_o (per_wr)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    gpq_strobe #(.PERW(PERW)) u_strobe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .period_i (period_w[g*PERW +: PERW]),
      .reload_i (per_wr),
      .strobe_o (strobe_w[g])
    );
  end

  for (genvar k = 0; k < NPINS; k++) begin : g_pin
    gpq_pin u_pin (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_i[k]),
      .mode_i   (qmode_e'(mode_w[2*k +: 2])),
      .strobe_i (strobe_w[k / GROUP]),
      .gpio_o   (gpio_dat_o[k]),
      .periph_o (periph_o[k])
    );
  end
endmodule

// File: tb/gpio_in_qual_bench.sv
module gpio_in_qual_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata, gpio_dat, periph;
  logic [31:0] pins = '0;

  always #5 clk = ~clk;

  gpio_in_qual u_gpio_in_qual (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pin_i(pins),
    .gpio_dat_o(gpio_dat), .periph_o(periph)
  );

  typedef struct {
    int          cyc;
    int          sel;   // 0 gpio, 1 periph, 2 rdata
    logic [31:0] mask;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    errs = 0;
  int    nchk = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_at(int d, int sel, logic [31:0] mask, logic [31:0] val, string tag);
    item_t it;
    it.cyc = cyc + d; it.sel = sel; it.mask = mask; it.val = val; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [31:0] e, string tag);
    reg_addr = a;
    expect_at(0, 2, 32'hFFFF_FFFF, e, tag);
    tick(1);
  endtask

  // monitor: compare queued items when their cycle arrives
  initial begin
    forever begin
      logic [31:0] got;
      @(negedge clk);
      #1;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].cyc == cyc) begin
          got = (sb[i].sel == 0) ? gpio_dat : (sb[i].sel == 1) ? periph : reg_rdata;
          nchk++;
          if ((got & sb[i].mask) !== (sb[i].val & sb[i].mask)) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h (mask %h)", sb[i].tag,
                     got & sb[i].mask, sb[i].val & sb[i].mask, sb[i].mask);
          end
          sb.delete(i);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errs++;
      nchk++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    // R1 reset state
    expect_at(0, 0, 32'hFFFF_FFFF, 32'h0, "R1 gpio after reset");
    expect_at(0, 1, 32'hFFFF_FFFF, 32'h0, "R1 periph after reset");
    rd_chk(2'd0, 32'h0, "R1 mode lo reset");
    rd_chk(2'd1, 32'h0, "R1 mode hi reset");
    rd_chk(2'd2, 32'h0, "R1 period reset");

    // R2 map: pin0 sync, pin1 3-sample, pin2 6-sample, pin3 bypass; pin16 3-sample, pin24 6-sample
    wr(2'd0, 32'h0000_00E4);
    wr(2'd1, 32'h0002_0001);
    rd_chk(2'd0, 32'h0000_00E4, "R2 mode lo readback");
    rd_chk(2'd1, 32'h0002_0001, "R2 mode hi readback");
    rd_chk(2'd3, 32'h0, "R2 unused address");
    tick(4);

    // R3 sync only on pin0
    pins[0] = 1'b1;
    expect_at(2, 0, 32'h1, 32'h0, "R3 gpio before edge 3");
    expect_at(3, 0, 32'h1, 32'h1, "R3 gpio at edge 3");
    expect_at(3, 1, 32'h1, 32'h1, "R3 periph at edge 3");
    tick(6);

    // R6 bypass on pin3
    pins[3] = 1'b1;
    expect_at(0, 1, 32'h8, 32'h8, "R6 periph immediate");
    expect_at(2, 0, 32'h8, 32'h0, "R6 gpio before edge 3");
    expect_at(3, 0, 32'h8, 32'h8, "R6 gpio at edge 3");
    tick(6);

    // R4 2-clock pulse rejected on pin1
    pins[1] = 1'b1;
    for (int d = 3; d <= 8; d++) expect_at(d, 0, 32'h2, 32'h0, "R4 2-clock pulse rejected");
    tick(2);
    pins[1] = 1'b0;
    tick(10);
    // R4 3-clock pulse accepted, then released
    pins[1] = 1'b1;
    expect_at(4, 0, 32'h2, 32'h0, "R4 3-clock pulse before edge 5");
    expect_at(5, 0, 32'h2, 32'h2, "R4 3-clock pulse at edge 5");
    expect_at(5, 1, 32'h2, 32'h2, "R4 periph follows qualified");
    expect_at(7, 0, 32'h2, 32'h2, "R4 holds high");
    expect_at(8, 0, 32'h2, 32'h0, "R4 low after 3 samples");
    tick(3);
    pins[1] = 1'b0;
    tick(10);

    // R5 5-clock pulse rejected on pin2
    pins[2] = 1'b1;
    for (int d = 6; d <= 12; d += 2) expect_at(d, 0, 32'h4, 32'h0, "R5 5-clock pulse rejected");
    tick(5);
    pins[2] = 1'b0;
    tick(12);
    // R5 steady level
    pins[2] = 1'b1;
    expect_at(7, 0, 32'h4, 32'h0, "R5 steady before edge 8");
    expect_at(8, 0, 32'h4, 32'h4, "R5 steady at edge 8");
    tick(12);

    // R7 / R8: group2 n=2, group3 n=1, group0 n=0
    wr(2'd2, 32'h0102_0000);
    pins[16] = 1'b1;
    pins[24] = 1'b1;
    pins[1]  = 1'b1;
    expect_at(11, 0, 32'h0001_0000, 32'h0, "R7 group2 before edge 12");
    expect_at(12, 0, 32'h0001_0000, 32'h0001_0000, "R7 group2 at edge 12");
    expect_at(13, 0, 32'h0100_0000, 32'h0, "R7 group3 before edge 14");
    expect_at(14, 0, 32'h0100_0000, 32'h0100_0000, "R7 group3 at edge 14");
    expect_at(4, 0, 32'h2, 32'h0, "R8 group0 unaffected before edge 5");
    expect_at(5, 0, 32'h2, 32'h2, "R8 group0 unaffected at edge 5");
    tick(1);
    rd_chk(2'd2, 32'h0102_0000, "R2 period readback");
    tick(30);

    // R7 divider restart on rewrite
    wr(2'd2, 32'h0102_0000);
    pins[16] = 1'b0;
    expect_at(11, 0, 32'h0001_0000, 32'h0001_0000, "R7 restart before edge 12");
    expect_at(12, 0, 32'h0001_0000, 32'h0, "R7 restart at edge 12");
    tick(20);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule